// File: doc/BRIEF.md
# Region-Tagged Address Translation Buffer

This block turns virtual addresses into physical addresses. The three highest bits of a virtual address pick one of eight region registers. That register gives a region identifier, a preferred page size and a flag saying whether a page-table walker may serve misses. The identifier and the virtual page are then compared against every translation entry. The entries live in two partitions. Pinned entries are written by software at an explicit slot and nothing else ever displaces them. Cached entries are placed by a rotating pointer, so each new cached entry overwrites the oldest slot. Every entry carries its own page size, so one lookup can match pages from 4 KiB up to 4 GiB.

A hit is then checked for protection. The entry's key must be present in the table of protection keys. The requester's privilege level must be at least as privileged as the entry's. The access kind must be allowed by the entry's rights code. A miss is only reported; no walker is built here. Software or a walker fills entries through a single command port. A chip uses one instance for instruction fetches and another for data accesses.

Lookups go through a three-state controller. In IDLE the block accepts a request and latches it. In SEARCH it compares all entries, checks permissions and registers the result. In REPORT it presents the response for exactly one cycle and then returns to IDLE. A request is taken only in IDLE. The transitions are IDLE to SEARCH when a request is presented, SEARCH to REPORT unconditionally, and REPORT to IDLE unconditionally.

Top module: `rtlb_xlate`

## Requirements
- R1: Bits [VA_W-1:VA_W-3] of the request address select region register 0..7, and an entry can only hit if its stored region identifier equals that register's identifier.
- R2: An entry's page-size code is log2 of its size (12..32). Address bits below it are not compared. On a hit with no fault, rsp_pa takes the bits below that size from the request address and the bits above from the entry's page base.
- R3: When several entries match, a pinned entry beats any cached one (rsp_hit_tr=1), and within a partition the lowest slot index wins.
- R4: Command op 2 writes pinned slot cmd_index and op 3 writes the cached slot under a round-robin pointer. The pointer starts at 0 and advances by one per op-3 command, wrapping after NTC. Op-3 commands never change pinned slots.
- R5: A lookup that hits nothing returns fault code 1 with rsp_pa=0 and rsp_hit_tr=0. Every response carries the selected region's walker-enable flag and preferred page size.
- R6: If the hit entry's key matches no key register that is marked valid (op 1 writes key register cmd_index, with cmd_flag as its valid bit), fault code 2 is returned.
- R7: If the request privilege number is greater than the entry's privilege number, fault code 3 is returned.
- R8: Rights code 0 allows read, 1 read/execute, 2 read/write, 3 read/write/execute, and codes 4..7 allow nothing. Access kind 0 is read, 1 write, 2 execute, and 3 is never allowed. A disallowed access returns fault code 4.
- R9: When more than one fault applies, the order is miss, then key, then privilege, then rights. Fault code 0 means success, and rsp_pa is 0 on any fault.
- R10: A request seen while ready=1 yields rsp_valid=1 for exactly one cycle, two clock edges after the accepting edge. Requests presented while ready=0 are ignored.
- R11: After reset the controller is in IDLE with ready=1. All entries and key registers are invalid, region registers are zero (op 0 writes region cmd_index with cmd_flag as walker enable), and the cached pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 region, 1 key register, 2 pinned entry, 3 cached entry |
| cmd_index | input | IDX_W | Target slot for ops 0..2 |
| cmd_flag | input | 1 | Walker enable (op 0) or valid bit (ops 1..3) |
| cmd_rid | input | RID_W | Region identifier |
| cmd_va | input | VA_W-3 | Entry virtual address without region bits |
| cmd_ps | input | 6 | Page-size code (log2) |
| cmd_ppn | input | PA_W-12 | Entry physical page base in 4 KiB units |
| cmd_ar | input | 3 | Entry rights code |
| cmd_pl | input | 2 | Entry privilege number |
| cmd_key | input | KEY_W | Entry key or key-register value |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address |
| req_cpl | input | 2 | Requester privilege number |
| req_acc | input | 2 | Access kind |
| ready | output | 1 | Controller is in IDLE |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 3 | Fault code |
| rsp_pa | output | PA_W | Physical address |
| rsp_hit_tr | output | 1 | Hit came from the pinned partition |
| rsp_walk_en | output | 1 | Region's walker enable |
| rsp_pref_ps | output | 6 | Region's preferred page-size code |

## Verification
The bench builds the block with two pinned slots, four cached slots and four key registers, keeping the 48-bit virtual and 40-bit physical widths. With only four cached slots, a fifth insert wraps the round-robin pointer, and duplicate matches can be placed in both partitions and inside one partition. The small sizes also allow full sweeps: all eleven page sizes with the first bit above each page flipped, every rights code against every access kind, and every privilege number.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
    localparam int REGION_BITS = 3;
    localparam int NREGION     = 8;
    localparam int PS_W        = 6;
    localparam int PG_SHIFT    = 12;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_REPORT = 2'd2
    } lk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_MISS   = 3'd1,
        FLT_KEY    = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_RIGHTS = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        OP_REGION = 2'd0,
        OP_KEY    = 2'd1,
        OP_PIN    = 2'd2,
        OP_CACHE  = 2'd3
    } cmd_op_e;

    // Rights code vs. access kind (0 read, 1 write, 2 execute)
    function automatic logic rights_allow(input logic [2:0] ar, input logic [1:0] acc);
        logic can_r, can_w, can_x;
        can_r = (ar <= 3'd3);
        can_w = (ar == 3'd2) || (ar == 3'd3);
        can_x = (ar == 3'd1) || (ar == 3'd3);
        unique case (acc)
            2'd0:    return can_r;
            2'd1:    return can_w;
            2'd2:    return can_x;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/rtlb_match.sv
module rtlb_match
    import rtlb_pkg::*;
#(
    parameter int N     = 8,
    parameter int LVA_W = 45,
    parameter int RID_W = 8
) (
    input  logic [N-1:0]         e_valid,
    input  logic [RID_W-1:0]     e_rid [N],
    input  logic [LVA_W-1:0]     e_va  [N],
    input  logic [PS_W-1:0]      e_ps  [N],
    input  logic [RID_W-1:0]     look_rid,
    input  logic [LVA_W-1:0]     look_va,
    output logic                 hit,
    output logic [$clog2(N)-1:0] hit_idx
);
    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [LVA_W-1:0] care;
        always_comb begin
            for (int b = 0; b < LVA_W; b++) begin
                care[b] = (b >= int'(e_ps[i]));
            end
        end
        assign match[i] = e_valid[i] && (e_rid[i] == look_rid) &&
                          (((e_va[i] ^ look_va) & care) == '0);
    end

    // Lowest matching slot wins
    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = ($clog2(N))'(i);
        end
    end
endmodule

// File: rtl/rtlb_perm.sv
module rtlb_perm
    import rtlb_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int NKEY  = 16
) (
    input  logic             hit,
    input  logic [2:0]       ent_ar,
    input  logic [1:0]       ent_pl,
    input  logic [KEY_W-1:0] ent_key,
    input  logic [NKEY-1:0]  key_v,
    input  logic [KEY_W-1:0] key_val [NKEY],
    input  logic [1:0]       cpl,
    input  logic [1:0]       acc,
    output fault_e           fault
);
    logic key_found;

    always_comb begin
        key_found = 1'b0;
        for (int k = 0; k < NKEY; k++) begin
            if (key_v[k] && (key_val[k] == ent_key)) key_found = 1'b1;
        end
    end

    always_comb begin
        if (!hit)                          fault = FLT_MISS;
        else if (!key_found)               fault = FLT_KEY;
        else if (cpl > ent_pl)             fault = FLT_PRIV;
        else if (!rights_allow(ent_ar, acc)) fault = FLT_RIGHTS;
        else                               fault = FLT_NONE;
    end
endmodule

// File: rtl/rtlb_xlate.sv
module rtlb_xlate
    import rtlb_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int PA_W  = 40,
    parameter int RID_W = 8,
    parameter int KEY_W = 8,
    parameter int NTR   = 8,
    parameter int NTC   = 16,
    parameter int NKEY  = 16,
    localparam int LVA_W  = VA_W - REGION_BITS,
    localparam int PPN_W  = PA_W - PG_SHIFT,
    localparam int TR_IW  = $clog2(NTR),
    localparam int TC_IW  = $clog2(NTC),
    localparam int KEY_IW = $clog2(NKEY),
    localparam int IDX_W  = (TR_IW > KEY_IW) ? ((TR_IW > REGION_BITS) ? TR_IW : REGION_BITS)
                                             : ((KEY_IW > REGION_BITS) ? KEY_IW : REGION_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic              cmd_flag,
    input  logic [RID_W-1:0]  cmd_rid,
    input  logic [LVA_W-1:0]  cmd_va,
    input  logic [PS_W-1:0]   cmd_ps,
    input  logic [PPN_W-1:0]  cmd_ppn,
    input  logic [2:0]        cmd_ar,
    input  logic [1:0]        cmd_pl,
    input  logic [KEY_W-1:0]  cmd_key,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_cpl,
    input  logic [1:0]        req_acc,
    output logic              ready,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_hit_tr,
    output logic              rsp_walk_en,
    output logic [PS_W-1:0]   rsp_pref_ps
);
    // Region registers
    logic [RID_W-1:0]   rr_rid [NREGION];
    logic [PS_W-1:0]    rr_ps  [NREGION];
    logic [NREGION-1:0] rr_walk;

    // Protection keys
    logic [NKEY-1:0]    key_v;
    logic [KEY_W-1:0]   key_val [NKEY];

    // Pinned partition
    logic [NTR-1:0]     tr_v;
    logic [RID_W-1:0]   tr_rid [NTR];
    logic [LVA_W-1:0]   tr_va  [NTR];
    logic [PS_W-1:0]    tr_ps  [NTR];
    logic [PPN_W-1:0]   tr_ppn [NTR];
    logic [2:0]         tr_ar  [NTR];
    logic [1:0]         tr_pl  [NTR];
    logic [KEY_W-1:0]   tr_key [NTR];

    // Cached partition
    logic [NTC-1:0]     tc_v;
    logic [RID_W-1:0]   tc_rid [NTC];
    logic [LVA_W-1:0]   tc_va  [NTC];
    logic [PS_W-1:0]    tc_ps  [NTC];
    logic [PPN_W-1:0]   tc_ppn [NTC];
    logic [2:0]         tc_ar  [NTC];
    logic [1:0]         tc_pl  [NTC];
    logic [KEY_W-1:0]   tc_key [NTC];
    logic [TC_IW-1:0]   tc_ptr;

    // Command port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_walk <= '0;
            key_v   <= '0;
            tr_v    <= '0;
            tc_v    <= '0;
            tc_ptr  <= '0;
            for (int r = 0; r < NREGION; r++) begin
                rr_rid[r] <= '0;
                rr_ps[r]  <= '0;
            end
            for (int k = 0; k < NKEY; k++) key_val[k] <= '0;
            for (int i = 0; i < NTR; i++) begin
                tr_rid[i] <= '0; tr_va[i] <= '0; tr_ps[i] <= '0; tr_ppn[i] <= '0;
                tr_ar[i]  <= '0; tr_pl[i] <= '0; tr_key[i] <= '0;
            end
            for (int i = 0; i < NTC; i++) begin
                tc_rid[i] <= '0; tc_va[i] <= '0; tc_ps[i] <= '0; tc_ppn[i] <= '0;
                tc_ar[i]  <= '0; tc_pl[i] <= '0; tc_key[i] <= '0;
            end
        end else if (cmd_valid) begin
            unique case (cmd_op_e'(cmd_op))
                OP_REGION: begin
                    rr_rid[cmd_index[REGION_BITS-1:0]]  <= cmd_rid;
                    rr_ps[cmd_index[REGION_BITS-1:0]]   <= cmd_ps;
                    rr_walk[cmd_index[REGION_BITS-1:0]] <= cmd_flag;
                end
                OP_KEY: begin
                    key_v[cmd_index[KEY_IW-1:0]]   <= cmd_flag;
                    key_val[cmd_index[KEY_IW-1:0]] <= cmd_key;
                end
                OP_PIN: begin
                    tr_v[cmd_index[TR_IW-1:0]]   <= cmd_flag;
                    tr_rid[cmd_index[TR_IW-1:0]] <= cmd_rid;
                    tr_va[cmd_index[TR_IW-1:0]]  <= cmd_va;
                    tr_ps[cmd_index[TR_IW-1:0]]  <= cmd_ps;
                    tr_ppn[cmd_index[TR_IW-1:0]] <= cmd_ppn;
                    tr_ar[cmd_index[TR_IW-1:0]]  <= cmd_ar;
                    tr_pl[cmd_index[TR_IW-1:0]]  <= cmd_pl;
                    tr_key[cmd_index[TR_IW-1:0]] <= cmd_key;
                end
                OP_CACHE: begin
                    tc_v[tc_ptr]   <= cmd_flag;
                    tc_rid[tc_ptr] <= cmd_rid;
                    tc_va[tc_ptr]  <= cmd_va;
                    tc_ps[tc_ptr]  <= cmd_ps;
                    tc_ppn[tc_ptr] <= cmd_ppn;
                    tc_ar[tc_ptr]  <= cmd_ar;
                    tc_pl[tc_ptr]  <= cmd_pl;
                    tc_key[tc_ptr] <= cmd_key;
                    tc_ptr         <= tc_ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Lookup controller
    lk_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_SEARCH : ST_IDLE;
            ST_SEARCH: state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic [VA_W-1:0] rq_va;
    logic [1:0]      rq_cpl, rq_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_va  <= '0;
            rq_cpl <= '0;
            rq_acc <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            rq_va  <= req_va;
            rq_cpl <= req_cpl;
            rq_acc <= req_acc;
        end
    end

    // Search datapath
    logic [REGION_BITS-1:0] rq_region;
    logic [RID_W-1:0]       rq_rid;
    assign rq_region = rq_va[VA_W-1:LVA_W];
    assign rq_rid    = rr_rid[rq_region];

    logic             tr_hit, tc_hit;
    logic [TR_IW-1:0] tr_idx;
    logic [TC_IW-1:0] tc_idx;

    rtlb_match #(.N(NTR), .LVA_W(LVA_W), .RID_W(RID_W)) u_tr_match (
        .e_valid(tr_v), .e_rid(tr_rid), .e_va(tr_va), .e_ps(tr_ps),
        .look_rid(rq_rid), .look_va(rq_va[LVA_W-1:0]),
        .hit(tr_hit), .hit_idx(tr_idx)
    );

    rtlb_match #(.N(NTC), .LVA_W(LVA_W), .RID_W(RID_W)) u_tc_match (
        .e_valid(tc_v), .e_rid(tc_rid), .e_va(tc_va), .e_ps(tc_ps),
        .look_rid(rq_rid), .look_va(rq_va[LVA_W-1:0]),
        .hit(tc_hit), .hit_idx(tc_idx)
    );

    logic [PPN_W-1:0] s_ppn;
    logic [PS_W-1:0]  s_ps;
    logic [2:0]       s_ar;
    logic [1:0]       s_pl;
    logic [KEY_W-1:0] s_key;

    always_comb begin
        if (tr_hit) begin
            s_ppn = tr_ppn[tr_idx]; s_ps = tr_ps[tr_idx]; s_ar = tr_ar[tr_idx];
            s_pl  = tr_pl[tr_idx];  s_key = tr_key[tr_idx];
        end else begin
            s_ppn = tc_ppn[tc_idx]; s_ps = tc_ps[tc_idx]; s_ar = tc_ar[tc_idx];
            s_pl  = tc_pl[tc_idx];  s_key = tc_key[tc_idx];
        end
    end

    logic [PA_W-1:0] off_mask, s_pa;
    always_comb begin
        for (int b = 0; b < PA_W; b++) off_mask[b] = (b < int'(s_ps));
        s_pa = ({s_ppn, {PG_SHIFT{1'b0}}} & ~off_mask) | (rq_va[PA_W-1:0] & off_mask);
    end

    fault_e s_fault;
    rtlb_perm #(.KEY_W(KEY_W), .NKEY(NKEY)) u_perm (
        .hit(tr_hit || tc_hit), .ent_ar(s_ar), .ent_pl(s_pl), .ent_key(s_key),
        .key_v(key_v), .key_val(key_val), .cpl(rq_cpl), .acc(rq_acc),
        .fault(s_fault)
    );

    // Result registers
    fault_e          res_fault;
    logic [PA_W-1:0] res_pa;
    logic            res_tr, res_walk;
    logic [PS_W-1:0] res_pref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_fault <= FLT_NONE;
            res_pa    <= '0;
            res_tr    <= 1'b0;
            res_walk  <= 1'b0;
            res_pref  <= '0;
        end else if (state_q == ST_SEARCH) begin
            res_fault <= s_fault;
            res_pa    <= (s_fault == FLT_NONE) ? s_pa : '0;
            res_tr    <= tr_hit;
            res_walk  <= rr_walk[rq_region];
            res_pref  <= rr_ps[rq_region];
        end
    end

    // Outputs
    always_comb begin
        ready       = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_REPORT);
        rsp_fault   = res_fault;
        rsp_pa      = res_pa;
        rsp_hit_tr  = res_tr;
        rsp_walk_en = res_walk;
        rsp_pref_ps = res_pref;
    end

    // Assertions
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_accept_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> ##1 rsp_valid);

    p_miss_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_MISS) |-> (rsp_pa == '0 && !rsp_hit_tr));

    p_tc_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CACHE && cmd_flag) |=> tc_v[$past(tc_ptr)]);

    p_pin_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CACHE) |=> (tr_v == $past(tr_v)));

    p_tr_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH && tr_hit) |=> rsp_hit_tr);

    p_fault_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault <= FLT_RIGHTS));
endmodule

// File: tb/sim_rtlb_xlate.sv
module sim_rtlb_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 48, PA_W = 40, LVA_W = 45, PPN_W = 28;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              cmd_valid = 0, cmd_flag = 0;
    logic [1:0]        cmd_op = 0, cmd_pl = 0;
    logic [2:0]        cmd_index = 0, cmd_ar = 0;
    logic [7:0]        cmd_rid = 0, cmd_key = 0;
    logic [LVA_W-1:0]  cmd_va = 0;
    logic [5:0]        cmd_ps = 0;
    logic [PPN_W-1:0]  cmd_ppn = 0;
    logic              req_valid = 0;
    logic [VA_W-1:0]   req_va = 0;
    logic [1:0]        req_cpl = 0, req_acc = 0;
    logic              ready, rsp_valid, rsp_hit_tr, rsp_walk_en;
    logic [2:0]        rsp_fault;
    logic [PA_W-1:0]   rsp_pa;
    logic [5:0]        rsp_pref_ps;

    rtlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .RID_W(8), .KEY_W(8),
                 .NTR(2), .NTC(4), .NKEY(4)) u0 (.*);

    int n_run = 0, n_fail = 0;
    logic [2:0]      o_fault;
    logic [PA_W-1:0] o_pa;
    logic            o_tr, o_walk;
    logic [5:0]      o_pref;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_region(input int r, input logic [7:0] rid, input logic [5:0] ps, input logic walk);
        cmd_valid = 1; cmd_op = 2'd0; cmd_index = 3'(r); cmd_rid = rid; cmd_ps = ps; cmd_flag = walk;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic set_key(input int k, input logic [7:0] key, input logic v);
        cmd_valid = 1; cmd_op = 2'd1; cmd_index = 3'(k); cmd_key = key; cmd_flag = v;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic put_entry(input logic [1:0] op, input int idx, input logic v, input logic [7:0] rid,
                             input logic [LVA_W-1:0] va, input logic [5:0] ps, input logic [PPN_W-1:0] ppn,
                             input logic [2:0] ar, input logic [1:0] pl, input logic [7:0] key);
        cmd_valid = 1; cmd_op = op; cmd_index = 3'(idx); cmd_flag = v; cmd_rid = rid; cmd_va = va;
        cmd_ps = ps; cmd_ppn = ppn; cmd_ar = ar; cmd_pl = pl; cmd_key = key;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic lookup(input logic [VA_W-1:0] va, input logic [1:0] cpl, input logic [1:0] acc);
        req_valid = 1; req_va = va; req_cpl = cpl; req_acc = acc;
        @(negedge clk); req_valid = 0;
        chk("R10 not ready while searching", 64'(ready), 64'd0);
        @(negedge clk);
        chk("R10 response strobe", 64'(rsp_valid), 64'd1);
        o_fault = rsp_fault; o_pa = rsp_pa; o_tr = rsp_hit_tr; o_walk = rsp_walk_en; o_pref = rsp_pref_ps;
        @(negedge clk);
        chk("R10 strobe lasts one cycle", 64'(rsp_valid), 64'd0);
    endtask

    function automatic logic [PA_W-1:0] exp_pa(input logic [VA_W-1:0] va, input logic [PPN_W-1:0] ppn, input int ps);
        logic [63:0] m, base;
        m    = (64'd1 << ps) - 64'd1;
        base = 64'(ppn) << 12;
        return PA_W'((base & ~m) | (64'(va) & m));
    endfunction

    function automatic logic [2:0] exp_rights(input int ar, input int acc);
        bit ok;
        if (acc == 0)      ok = (ar < 4);
        else if (acc == 1) ok = (ar == 2 || ar == 3);
        else if (acc == 2) ok = (ar == 1 || ar == 3);
        else               ok = 0;
        return ok ? 3'd0 : 3'd4;
    endfunction

    function automatic logic [LVA_W-1:0] pg(input int k);
        return LVA_W'(45'h500000 + (k << 12));
    endfunction

    localparam logic [LVA_W-1:0] PVA = 45'h1A2B3C4D5E6F;
    int pss [11] = '{12, 13, 14, 16, 18, 20, 22, 24, 26, 28, 32};

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready after reset", 64'(ready), 64'd1);
        chk("R11 no response after reset", 64'(rsp_valid), 64'd0);
        rst_n = 1;
        @(negedge clk);
        lookup({3'd0, PVA}, 0, 0);
        chk("R11 empty buffer misses", 64'(o_fault), 64'd1);
        chk("R11 region regs zero", 64'({o_walk, o_pref}), 64'd0);

        for (int r = 0; r < 8; r++) set_region(r, 8'(8'h10 + r), 6'(12 + r), r[0]);
        set_key(0, 8'd5, 1);

        // R2 page-size sweep
        foreach (pss[i]) begin
            logic [LVA_W-1:0] m45, v;
            m45 = LVA_W'((64'd1 << pss[i]) - 1);
            put_entry(2'd2, 0, 1, 8'h12, PVA, 6'(pss[i]), 28'hABCDE12, 3'd3, 2'd3, 8'd5);
            v = PVA ^ (45'h0F0F0F0F0F0F & m45);
            lookup({3'd2, v}, 0, 0);
            chk($sformatf("R2 ps%0d fault", pss[i]), 64'(o_fault), 64'd0);
            chk($sformatf("R2 ps%0d pa", pss[i]), 64'(o_pa), 64'(exp_pa({3'd2, v}, 28'hABCDE12, pss[i])));
            lookup({3'd2, PVA ^ (45'h1 << pss[i])}, 0, 0);
            chk($sformatf("R2 ps%0d bit above page compared", pss[i]), 64'(o_fault), 64'd1);
        end

        // R1 region selection
        lookup({3'd3, PVA}, 0, 0);
        chk("R1 other region misses", 64'(o_fault), 64'd1);
        put_entry(2'd2, 1, 1, 8'h13, PVA, 6'd12, 28'h111, 3'd3, 2'd3, 8'd5);
        lookup({3'd3, PVA}, 0, 0);
        chk("R1 region 3 hit pa", 64'(o_pa), 64'h111E6F);
        chk("R1 region 3 pinned", 64'(o_tr), 64'd1);
        lookup({3'd2, PVA}, 0, 0);
        chk("R1 region 2 pa", 64'(o_pa), 64'(exp_pa({3'd2, PVA}, 28'hABCDE12, 32)));

        // R5 miss reporting
        lookup({3'd1, PVA}, 0, 0);
        chk("R5 miss code", 64'(o_fault), 64'd1);
        chk("R5 miss pa zero", 64'(o_pa), 64'd0);
        chk("R5 walk enable region 1", 64'(o_walk), 64'd1);
        chk("R5 preferred size region 1", 64'(o_pref), 64'd13);
        lookup({3'd4, PVA}, 0, 0);
        chk("R5 walk enable region 4", 64'(o_walk), 64'd0);
        chk("R5 preferred size region 4", 64'(o_pref), 64'd16);

        // R4 round-robin cached inserts
        put_entry(2'd2, 0, 0, 8'h0, '0, 6'd12, '0, 3'd0, 2'd0, 8'd0);
        for (int k = 0; k < 5; k++)
            put_entry(2'd3, 0, 1, 8'h15, pg(k), 6'd12, 28'(28'h200 + k), 3'd3, 2'd3, 8'd5);
        lookup({3'd5, pg(0) + 45'h34}, 0, 0);
        chk("R4 oldest slot overwritten", 64'(o_fault), 64'd1);
        for (int k = 1; k < 5; k++) begin
            lookup({3'd5, pg(k) + 45'h34}, 0, 0);
            chk($sformatf("R4 cached page %0d pa", k), 64'(o_pa), 64'(((64'h200 + k) << 12) | 64'h34));
            chk($sformatf("R4 cached page %0d not pinned", k), 64'(o_tr), 64'd0);
        end
        lookup({3'd3, PVA}, 0, 0);
        chk("R4 pinned slot survives inserts", 64'(o_pa), 64'h111E6F);

        // R3 priority
        put_entry(2'd2, 0, 1, 8'h15, pg(2), 6'd12, 28'h777, 3'd3, 2'd3, 8'd5);
        lookup({3'd5, pg(2) + 45'h34}, 0, 0);
        chk("R3 pinned beats cached pa", 64'(o_pa), 64'h777034);
        chk("R3 pinned flag", 64'(o_tr), 64'd1);
        put_entry(2'd2, 1, 1, 8'h15, pg(2), 6'd16, 28'h888, 3'd3, 2'd3, 8'd5);
        lookup({3'd5, pg(2) + 45'h34}, 0, 0);
        chk("R3 lowest pinned slot wins", 64'(o_pa), 64'h777034);
        put_entry(2'd2, 0, 0, 8'h0, '0, 6'd12, '0, 3'd0, 2'd0, 8'd0);
        lookup({3'd5, pg(2) + 45'h34}, 0, 0);
        chk("R3 remaining pinned slot", 64'(o_pa), 64'(exp_pa({3'd5, pg(2) + 45'h34}, 28'h888, 16)));
        put_entry(2'd2, 1, 0, 8'h0, '0, 6'd12, '0, 3'd0, 2'd0, 8'd0);
        lookup({3'd5, pg(2) + 45'h34}, 0, 0);
        chk("R3 falls back to cached", 64'(o_pa), 64'h202034);
        chk("R3 cached flag", 64'(o_tr), 64'd0);
        put_entry(2'd3, 0, 1, 8'h15, pg(3), 6'd12, 28'h999, 3'd3, 2'd3, 8'd5);
        lookup({3'd5, pg(3) + 45'h34}, 0, 0);
        chk("R3 lowest cached slot wins", 64'(o_pa), 64'h999034);
        lookup({3'd5, pg(1) + 45'h34}, 0, 0);
        chk("R4 pointer continued to slot 1", 64'(o_fault), 64'd1);

        // R6 protection keys
        put_entry(2'd2, 0, 1, 8'h16, PVA, 6'd12, 28'h321, 3'd3, 2'd3, 8'd9);
        lookup({3'd6, PVA}, 0, 0);
        chk("R6 unknown key faults", 64'(o_fault), 64'd2);
        set_key(3, 8'd9, 1);
        lookup({3'd6, PVA}, 0, 0);
        chk("R6 key present", 64'(o_fault), 64'd0);
        chk("R6 key present pa", 64'(o_pa), 64'h321E6F);
        set_key(3, 8'd9, 0);
        lookup({3'd6, PVA}, 0, 0);
        chk("R6 invalid key register ignored", 64'(o_fault), 64'd2);
        chk("R9 pa zero on fault", 64'(o_pa), 64'd0);

        // R7 privilege
        put_entry(2'd2, 0, 1, 8'h16, PVA, 6'd12, 28'h321, 3'd3, 2'd1, 8'd5);
        for (int c = 0; c < 4; c++) begin
            lookup({3'd6, PVA}, 2'(c), 0);
            chk($sformatf("R7 cpl %0d", c), 64'(o_fault), (c > 1) ? 64'd3 : 64'd0);
        end

        // R8 rights sweep
        for (int a = 0; a < 8; a++) begin
            put_entry(2'd2, 0, 1, 8'h16, PVA, 6'd12, 28'h321, 3'(a), 2'd3, 8'd5);
            for (int k = 0; k < 4; k++) begin
                lookup({3'd6, PVA}, 0, 2'(k));
                chk($sformatf("R8 ar %0d acc %0d", a, k), 64'(o_fault), 64'(exp_rights(a, k)));
            end
        end

        // R9 fault ordering
        put_entry(2'd2, 0, 1, 8'h16, PVA, 6'd12, 28'h321, 3'd0, 2'd0, 8'd9);
        lookup({3'd6, PVA}, 3, 1);
        chk("R9 key before privilege", 64'(o_fault), 64'd2);
        set_key(2, 8'd9, 1);
        lookup({3'd6, PVA}, 3, 1);
        chk("R9 privilege before rights", 64'(o_fault), 64'd3);
        lookup({3'd6, PVA}, 0, 1);
        chk("R9 rights last", 64'(o_fault), 64'd4);

        // R10 request while busy is ignored
        req_valid = 1; req_va = {3'd6, PVA}; req_cpl = 0; req_acc = 0;
        @(negedge clk);
        req_va = {3'd5, pg(1)};
        @(negedge clk);
        req_valid = 0;
        chk("R10 strobe for first request", 64'(rsp_valid), 64'd1);
        chk("R10 result from first request", 64'(rsp_pa), 64'h321E6F);
        @(negedge clk);
        chk("R10 busy request ignored", 64'({rsp_valid, ready}), 64'b01);
        @(negedge clk);
        chk("R10 still idle", 64'({rsp_valid, ready}), 64'b01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule